// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block makes every hazard decision for a five-stage in-order pipeline (fetch, decode/register-read, execute, memory, writeback). Each cycle it looks at the two source register numbers of the instruction in execute. It also looks at the destination, register-write flag and load flag of the instructions in the memory and writeback stages, and at a redirect flag raised in execute by a jump or a taken branch. From these it forwards operands, stalls on a load-use dependency, and flushes the front of the pipe on a redirect.

The block contains the two execute-stage operand multiplexers. Each multiplexer picks between the register-file value latched in the decode/execute register, the ALU result held in the execute/memory register, and the writeback result. The block drives the PC enable, the enables of the fetch/decode and decode/execute registers, and the clears of the fetch/decode, decode/execute and execute/memory registers. It also selects the PC source and passes the redirect target. The block is purely combinational. The pipeline registers, ALU, register file and memories sit outside it.

A load is seen while it is in the memory stage, which is one stage later than usual. The bubble is therefore placed in the execute/memory register. The dependent instruction waits in execute and then takes the loaded value from writeback.

Top module: `hazard_ctl`

## Requirements
- R1: Operand select n (n = 0, 1) is 1 when execute source n equals the memory-stage destination and that stage writes the register file. Otherwise it is 2 when source n equals the writeback-stage destination and that stage writes. Otherwise it is 0.
- R2: When both later stages match a source, the memory-stage value (select 1) is used.
- R3: A destination of register 0 never matches: it neither forwards a value nor raises a stall.
- R4: Operand output n equals the decode/execute register value for select 0, the memory-stage ALU result for select 1, and the writeback result for select 2.
- R5: A load-use hazard exists when the memory-stage instruction writes the register file, is a load, and has a destination equal to either execute source. When a hazard exists and there is no redirect, the PC enable, fetch/decode enable and decode/execute enable are 0 and the execute/memory clear is 1.
- R6: Without a stall, the PC enable and execute/memory clear follow their pass-through inputs, and the fetch/decode and decode/execute enables are 1.
- R7: With the redirect flag set, the fetch/decode and decode/execute clears are 1. Otherwise both follow the front clear input.
- R8: The PC source select equals the execute-stage redirect flag, and the PC target equals the execute-stage ALU result.
- R9: When a redirect and a load-use hazard occur together, the redirect wins: the front registers are cleared and the enables and execute/memory clear behave as in R6.
- R10: An operand select never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs0 | input | 5 | Source register 0 of the execute-stage instruction |
| ex_rs1 | input | 5 | Source register 1 of the execute-stage instruction |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes the register file |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes the register file |
| ex_redirect | input | 1 | Jump or taken branch resolved in execute |
| ex_rf_val0 | input | 64 | Operand 0 read from the register file (decode/execute register) |
| ex_rf_val1 | input | 64 | Operand 1 read from the register file (decode/execute register) |
| mem_alu_val | input | 64 | ALU result held in the execute/memory register |
| wb_val | input | 64 | Writeback result (memory or ALU) |
| ex_alu_val | input | 64 | ALU result of the execute stage |
| pc_en_in | input | 1 | Normal PC enable |
| exmem_clr_in | input | 1 | Normal execute/memory clear |
| front_clr_in | input | 1 | Normal fetch/decode and decode/execute clear |
| fwd_sel0 | output | 2 | Operand 0 forwarding select |
| fwd_sel1 | output | 2 | Operand 1 forwarding select |
| ex_opnd0 | output | 64 | Forwarded operand 0 |
| ex_opnd1 | output | 64 | Forwarded operand 1 |
| pc_en | output | 1 | PC enable |
| ifid_en | output | 1 | Fetch/decode register enable |
| idex_en | output | 1 | Decode/execute register enable |
| exmem_clr | output | 1 | Execute/memory register clear |
| ifid_clr | output | 1 | Fetch/decode register clear |
| idex_clr | output | 1 | Decode/execute register clear |
| pc_src_sel | output | 1 | PC source: 1 selects the redirect target |
| pc_target | output | 64 | Redirect target |

## Verification
The bench builds the block with its default parameters: 5-bit register numbers, 64-bit data and two sources. In the random part, register numbers are drawn only from registers 0 to 3. This makes matches in both stages, matches on both sources, and destinations of register 0 common, so the priority and register-0 cases come up many times. The 64-bit data values are drawn independently for each source. A wrong operand selection is then very likely to give a wrong output value.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_MEMSTG  = 2'd1,
    SRC_WBSTG   = 2'd2
  } opnd_src_e;

  // Priority: the memory stage holds the younger result.
  function automatic opnd_src_e choose_src(input logic hit_mem, input logic hit_wb);
    if (hit_mem)     return SRC_MEMSTG;
    else if (hit_wb) return SRC_WBSTG;
    else             return SRC_REGFILE;
  endfunction

endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_reg,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output opnd_src_e         sel,
  output logic              hit_mem,
  output logic              hit_wb
);

  function automatic logic producer_match(input logic [REG_AW-1:0] src,
                                          input logic [REG_AW-1:0] dst,
                                          input logic wr);
    return wr && (dst != '0) && (src == dst);
  endfunction

  always_comb begin
    hit_mem = producer_match(src_reg, mem_dst, mem_wr);
    hit_wb  = producer_match(src_reg, wb_dst, wb_wr);
    sel     = choose_src(hit_mem, hit_wb);
  end

endmodule

// File: rtl/hzd_opnd_mux.sv
module hzd_opnd_mux
  import hzd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  opnd_src_e         sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);

  always_comb begin
    unique case (sel)
      SRC_MEMSTG: opnd = mem_val;
      SRC_WBSTG:  opnd = wb_val;
      default:    opnd = rf_val;
    endcase
  end

endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] src_regs,
  input  logic [REG_AW-1:0]              mem_dst,
  input  logic                           mem_wr,
  input  logic                           mem_ld,
  output logic                           hazard
);

  logic [NUM_SRC-1:0] src_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
    assign src_hit[s] = (src_regs[s] == mem_dst);
  end

  assign hazard = mem_wr && mem_ld && (mem_dst != '0) && (|src_hit);

endmodule

// File: rtl/hzd_flow_ctl.sv
module hzd_flow_ctl (
  input  logic ld_hazard,
  input  logic redirect,
  input  logic pc_en_in,
  input  logic exmem_clr_in,
  input  logic front_clr_in,
  output logic stall_taken,
  output logic pc_en,
  output logic ifid_en,
  output logic idex_en,
  output logic exmem_clr,
  output logic ifid_clr,
  output logic idex_clr
);

  // A redirect squashes the younger instructions, so a stall on their behalf is moot.
  assign stall_taken = ld_hazard && !redirect;

  always_comb begin
    if (stall_taken) begin
      pc_en     = 1'b0;
      ifid_en   = 1'b0;
      idex_en   = 1'b0;
      exmem_clr = 1'b1;
    end else begin
      pc_en     = pc_en_in;
      ifid_en   = 1'b1;
      idex_en   = 1'b1;
      exmem_clr = exmem_clr_in;
    end
    ifid_clr = redirect ? 1'b1 : front_clr_in;
    idex_clr = redirect ? 1'b1 : front_clr_in;
  end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int DATA_W = 64
) (
  input  logic [REG_AW-1:0] ex_rs0,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  input  logic              ex_redirect,
  input  logic [DATA_W-1:0] ex_rf_val0,
  input  logic [DATA_W-1:0] ex_rf_val1,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [DATA_W-1:0] ex_alu_val,
  input  logic              pc_en_in,
  input  logic              exmem_clr_in,
  input  logic              front_clr_in,
  output logic [1:0]        fwd_sel0,
  output logic [1:0]        fwd_sel1,
  output logic [DATA_W-1:0] ex_opnd0,
  output logic [DATA_W-1:0] ex_opnd1,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              idex_en,
  output logic              exmem_clr,
  output logic              ifid_clr,
  output logic              idex_clr,
  output logic              pc_src_sel,
  output logic [DATA_W-1:0] pc_target
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] src_regs;
  logic [NUM_SRC-1:0][DATA_W-1:0] rf_vals;
  logic [NUM_SRC-1:0][DATA_W-1:0] opnds;
  opnd_src_e [NUM_SRC-1:0]        sels;
  logic [NUM_SRC-1:0]             hit_mem_v;
  logic [NUM_SRC-1:0]             hit_wb_v;

  // Named internal events for the checker
  logic ld_hazard;
  logic stall_taken;

  assign src_regs = {ex_rs1, ex_rs0};
  assign rf_vals  = {ex_rf_val1, ex_rf_val0};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hzd_fwd_pick #(.REG_AW(REG_AW)) u_pick (
      .src_reg (src_regs[s]),
      .mem_dst (mem_rd),
      .mem_wr  (mem_wen),
      .wb_dst  (wb_rd),
      .wb_wr   (wb_wen),
      .sel     (sels[s]),
      .hit_mem (hit_mem_v[s]),
      .hit_wb  (hit_wb_v[s])
    );

    hzd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sels[s]),
      .rf_val  (rf_vals[s]),
      .mem_val (mem_alu_val),
      .wb_val  (wb_val),
      .opnd    (opnds[s])
    );
  end

  hzd_loaduse #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_loaduse (
    .src_regs (src_regs),
    .mem_dst  (mem_rd),
    .mem_wr   (mem_wen),
    .mem_ld   (mem_load),
    .hazard   (ld_hazard)
  );

  hzd_flow_ctl u_flow (
    .ld_hazard    (ld_hazard),
    .redirect     (ex_redirect),
    .pc_en_in     (pc_en_in),
    .exmem_clr_in (exmem_clr_in),
    .front_clr_in (front_clr_in),
    .stall_taken  (stall_taken),
    .pc_en        (pc_en),
    .ifid_en      (ifid_en),
    .idex_en      (idex_en),
    .exmem_clr    (exmem_clr),
    .ifid_clr     (ifid_clr),
    .idex_clr     (idex_clr)
  );

  assign fwd_sel0   = sels[0];
  assign fwd_sel1   = sels[1];
  assign ex_opnd0   = opnds[0];
  assign ex_opnd1   = opnds[1];
  assign pc_src_sel = ex_redirect;
  assign pc_target  = ex_alu_val;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 64
) (
  input logic [REG_AW-1:0] ex_rs0,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wen,
  input logic              ex_redirect,
  input logic [DATA_W-1:0] mem_alu_val,
  input logic [DATA_W-1:0] wb_val,
  input logic [DATA_W-1:0] ex_opnd0,
  input logic [1:0]        fwd_sel0,
  input logic [1:0]        fwd_sel1,
  input logic              pc_en,
  input logic              ifid_en,
  input logic              idex_en,
  input logic              exmem_clr,
  input logic              ifid_clr,
  input logic              idex_clr,
  input logic              ld_hazard,
  input logic              stall_taken
);

  always_comb begin
    // R10
    sel_range_chk: assert (fwd_sel0 != 2'd3 && fwd_sel1 != 2'd3);
    // R3
    no_x0_fwd_chk: assert (fwd_sel0 == 2'd0 || ex_rs0 != '0);
    // R2
    mem_priority_chk: assert (!(mem_wen && mem_rd != '0 && mem_rd == ex_rs0) || fwd_sel0 == 2'd1);
    // R4
    opnd_mem_chk: assert (fwd_sel0 != 2'd1 || ex_opnd0 == mem_alu_val);
    // R4
    opnd_wb_chk: assert (fwd_sel0 != 2'd2 || ex_opnd0 == wb_val);
    // R5
    stall_outputs_chk: assert (!stall_taken || (!pc_en && !ifid_en && !idex_en && exmem_clr));
    // R7
    redirect_flush_chk: assert (!ex_redirect || (ifid_clr && idex_clr));
    // R9
    redirect_wins_chk: assert (!(ex_redirect && ld_hazard) || (ifid_en && idex_en));
  end

endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_chk (
  .ex_rs0      (ex_rs0),
  .mem_rd      (mem_rd),
  .mem_wen     (mem_wen),
  .ex_redirect (ex_redirect),
  .mem_alu_val (mem_alu_val),
  .wb_val      (wb_val),
  .ex_opnd0    (ex_opnd0),
  .fwd_sel0    (fwd_sel0),
  .fwd_sel1    (fwd_sel1),
  .pc_en       (pc_en),
  .ifid_en     (ifid_en),
  .idex_en     (idex_en),
  .exmem_clr   (exmem_clr),
  .ifid_clr    (ifid_clr),
  .idex_clr    (idex_clr),
  .ld_hazard   (ld_hazard),
  .stall_taken (stall_taken)
);

// File: tb/hazard_ctl_bench.sv
`timescale 1ns/1ps
module hazard_ctl_bench;

  localparam int RW = 5;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0] ex_rs0, ex_rs1, mem_rd, wb_rd;
  logic mem_wen, mem_load, wb_wen, ex_redirect;
  logic [DW-1:0] ex_rf_val0, ex_rf_val1, mem_alu_val, wb_val, ex_alu_val;
  logic pc_en_in, exmem_clr_in, front_clr_in;
  logic [1:0] fwd_sel0, fwd_sel1;
  logic [DW-1:0] ex_opnd0, ex_opnd1, pc_target;
  logic pc_en, ifid_en, idex_en, exmem_clr, ifid_clr, idex_clr, pc_src_sel;

  hazard_ctl #(.REG_AW(RW), .DATA_W(DW)) u_hazard_ctl (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] want_sel(input logic [RW-1:0] rs);
    logic m, w;
    m = mem_wen && mem_rd != 0 && mem_rd == rs;
    w = wb_wen && wb_rd != 0 && wb_rd == rs;
    if (m) return 2'd1;
    if (w) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [DW-1:0] want_opnd(input logic [1:0] s, input logic [DW-1:0] rf);
    case (s)
      2'd1: return mem_alu_val;
      2'd2: return wb_val;
      default: return rf;
    endcase
  endfunction

  function automatic logic want_stall();
    return !ex_redirect && mem_wen && mem_load && mem_rd != 0 &&
           (mem_rd == ex_rs0 || mem_rd == ex_rs1);
  endfunction

  task automatic check_all(input string tag);
    logic [1:0] s0, s1;
    logic st;
    s0 = want_sel(ex_rs0);
    s1 = want_sel(ex_rs1);
    st = want_stall();
    check("R1", {tag, " sel0"}, fwd_sel0, s0);
    check("R1", {tag, " sel1"}, fwd_sel1, s1);
    check("R4", {tag, " opnd0"}, ex_opnd0, want_opnd(s0, ex_rf_val0));
    check("R4", {tag, " opnd1"}, ex_opnd1, want_opnd(s1, ex_rf_val1));
    check(st ? "R5" : "R6", {tag, " pc_en"}, pc_en, st ? 1'b0 : pc_en_in);
    check(st ? "R5" : "R6", {tag, " ifid_en"}, ifid_en, !st);
    check(st ? "R5" : "R6", {tag, " idex_en"}, idex_en, !st);
    check(st ? "R5" : "R6", {tag, " exmem_clr"}, exmem_clr, st ? 1'b1 : exmem_clr_in);
    check("R7", {tag, " ifid_clr"}, ifid_clr, ex_redirect | front_clr_in);
    check("R7", {tag, " idex_clr"}, idex_clr, ex_redirect | front_clr_in);
    check("R8", {tag, " pc_src"}, pc_src_sel, ex_redirect);
    check("R8", {tag, " target"}, pc_target, ex_alu_val);
  endtask

  task automatic idle();
    ex_rs0 = 0; ex_rs1 = 0; mem_rd = 0; wb_rd = 0;
    mem_wen = 0; mem_load = 0; wb_wen = 0; ex_redirect = 0;
    ex_rf_val0 = 64'h1111; ex_rf_val1 = 64'h2222; mem_alu_val = 64'h3333;
    wb_val = 64'h4444; ex_alu_val = 64'h5555;
    pc_en_in = 1; exmem_clr_in = 0; front_clr_in = 0;
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic settle(); #1; endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int seed;
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step(); settle();
    check_all("reset idle");
    check("R6", "reset pc_en", pc_en, 1'b1);

    // R1: back-to-back ALU dependencies: add reads both results of the two prior ops
    step(); idle();
    ex_rs0 = 5'd11; ex_rs1 = 5'd12; mem_rd = 5'd12; mem_wen = 1; wb_rd = 5'd11; wb_wen = 1;
    settle(); check_all("alu chain");
    check("R1", "chain sel0 wb", fwd_sel0, 2'd2);
    check("R1", "chain sel1 mem", fwd_sel1, 2'd1);

    // R2: both stages write the same register
    step(); idle();
    ex_rs0 = 5'd7; ex_rs1 = 5'd7; mem_rd = 5'd7; wb_rd = 5'd7; mem_wen = 1; wb_wen = 1;
    settle();
    check("R2", "both match sel0", fwd_sel0, 2'd1);
    check("R2", "both match opnd1", ex_opnd1, 64'h3333);

    // R3: register 0 as destination
    step(); idle();
    mem_wen = 1; wb_wen = 1; mem_load = 1;
    settle();
    check("R3", "x0 sel0", fwd_sel0, 2'd0);
    check("R3", "x0 opnd0", ex_opnd0, 64'h1111);
    check("R3", "x0 no stall", pc_en, 1'b1);

    // R5: load followed immediately by dependent instruction
    step(); idle();
    ex_rs0 = 5'd12; ex_rs1 = 5'd3; mem_rd = 5'd12; mem_wen = 1; mem_load = 1;
    settle(); check_all("load use");
    check("R5", "ld stall pc_en", pc_en, 1'b0);
    check("R5", "ld bubble", exmem_clr, 1'b1);
    // next cycle: load in writeback, bubble in memory stage
    step(); idle();
    ex_rs0 = 5'd12; ex_rs1 = 5'd3; wb_rd = 5'd12; wb_wen = 1;
    settle();
    check("R1", "after stall sel0", fwd_sel0, 2'd2);
    check("R6", "after stall ifid_en", ifid_en, 1'b1);

    // R6: pass-through inputs with no stall, load not dependent
    step(); idle();
    ex_rs0 = 5'd4; ex_rs1 = 5'd5; mem_rd = 5'd6; mem_wen = 1; mem_load = 1;
    pc_en_in = 0; exmem_clr_in = 1;
    settle();
    check("R6", "pass pc_en", pc_en, 1'b0);
    check("R6", "pass exmem_clr", exmem_clr, 1'b1);
    check("R6", "pass idex_en", idex_en, 1'b1);

    // R7 R8: jump squashes the following instruction
    step(); idle();
    ex_redirect = 1; ex_alu_val = 64'hDEAD_BEEF_0000_0040;
    settle(); check_all("jump");
    check("R7", "jump ifid_clr", ifid_clr, 1'b1);
    check("R8", "jump target", pc_target, 64'hDEAD_BEEF_0000_0040);
    step(); idle(); front_clr_in = 1;
    settle();
    check("R7", "front clr pass", idex_clr, 1'b1);

    // R9: redirect and load-use together
    step(); idle();
    ex_redirect = 1; ex_rs0 = 5'd9; mem_rd = 5'd9; mem_wen = 1; mem_load = 1;
    settle(); check_all("redirect+ld");
    check("R9", "redirect wins pc_en", pc_en, 1'b1);
    check("R9", "redirect wins exmem_clr", exmem_clr, 1'b0);

    // random mix, registers restricted to x0..x3
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 400; i++) begin
      step();
      ex_rs0 = RW'($urandom % 4); ex_rs1 = RW'($urandom % 4);
      mem_rd = RW'($urandom % 4); wb_rd = RW'($urandom % 4);
      mem_wen = 1'($urandom); mem_load = 1'($urandom); wb_wen = 1'($urandom);
      ex_redirect = (($urandom % 5) == 0);
      ex_rf_val0 = {$urandom, $urandom}; ex_rf_val1 = {$urandom, $urandom};
      mem_alu_val = {$urandom, $urandom}; wb_val = {$urandom, $urandom};
      ex_alu_val = {$urandom, $urandom};
      pc_en_in = 1'($urandom); exmem_clr_in = 1'($urandom); front_clr_in = 1'($urandom);
      settle();
      check_all("rand");
      check("R10", "rand sel range", {1'b0, fwd_sel0 == 2'd3 || fwd_sel1 == 2'd3}, 2'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule